// File: doc/BRIEF.md
# Serial Command Packet to Register Bus Bridge

This block sits between a byte-level serial receiver/transmitter pair and an on-chip register bus. It takes received bytes, each marked by a one-cycle valid strobe, and assembles them into framed command packets. A complete packet with a correct checksum becomes a single register write or register read on the bus. The 16-bit result of a read goes back to the host as two bytes on a transmit handshake.

A packet begins with a sync byte and a sequence byte, then a command byte and a length byte. Next comes a 16-bit address, and for writes a 16-bit data word, both least significant byte first. A checksum byte closes the packet. Malformed or corrupted packets never reach the bus. The parser falls back to searching for the sync byte. The serial bit framing (8 data bits, LSB first, start and stop bits) belongs to the neighbouring receiver and transmitter and is not handled here.

Top module: `pkt_bridge`

## Requirements
- R1: While idle, the parser leaves its search state only on the sync byte 0xAA; the next byte is the sequence byte.
- R2: The sequence byte may take any value; it counts only toward the checksum, so packets with successive sequence values 0x1D, 0x1E, ... are all accepted.
- R3: Command byte 0x03 selects a register write and 0x04 a register read.
- R4: The address, and for a write the data word, arrive as two bytes each, low byte first, and appear unchanged on `bus_addr` / `bus_wdata`.
- R5: A valid write produces exactly one `bus_wr` pulse one clock wide, and no `bus_rd`.
- R6: A valid read produces exactly one `bus_rd` pulse one clock wide; `bus_rdata` is sampled in that cycle.
- R7: After a read, the sampled word is offered on `tx_byte` as two bytes, low byte first, each handed over in a cycle where `tx_send` and `tx_ready` are both high.
- R8: The last byte must equal the modulo-256 sum of all earlier bytes of the packet, sync byte included; otherwise no bus cycle occurs.
- R9: Bytes other than 0xAA received while searching are ignored and cause no bus cycle.
- R10: A command byte other than 0x03 or 0x04 drops the packet; the next 0xAA starts a new one.
- R11: A length byte other than 4 for a write or 2 for a read drops the packet.
- R12: While `tx_send` is high and `tx_ready` is low, `tx_send` stays high and `tx_byte` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| rx_byte | input | 8 | Received byte |
| rx_valid | input | 1 | One-cycle strobe: `rx_byte` holds a new byte |
| bus_addr | output | 16 | Register address |
| bus_wdata | output | 16 | Register write data |
| bus_wr | output | 1 | One-cycle write strobe |
| bus_rd | output | 1 | One-cycle read strobe |
| bus_rdata | input | 16 | Read data, valid in the cycle `bus_rd` is high |
| tx_byte | output | 8 | Reply byte to transmit |
| tx_send | output | 1 | `tx_byte` is ready to be transmitted |
| tx_ready | input | 1 | Transmitter accepts the byte this cycle |

## Verification
The bench builds the bridge with its default codes: sync 0xAA, write 0x03 and read 0x04. These are the values that the packet builder in the bench encodes. With those values it can send well-formed packets and also packets with one field damaged: checksum, command or length. It can also put noise bytes ahead of the sync byte. Holding `tx_ready` low in the middle of a reply tests that the reply bytes are held stable under back-pressure.

// File: rtl/pktbr_pkg.sv
// Shared packet-bridge definitions.
// Assumes: fixed 16-bit address and data fields carried as bytes.
package pktbr_pkg;
    localparam int BYTE_W     = 8;
    localparam int ADDR_W     = 16;
    localparam int DATA_W     = 16;
    localparam int ADDR_BYTES = ADDR_W / BYTE_W;
    localparam int DATA_BYTES = DATA_W / BYTE_W;
    localparam int WR_LEN     = ADDR_BYTES + DATA_BYTES;
    localparam int RD_LEN     = ADDR_BYTES;

    typedef enum logic [3:0] {
        P_HUNT, P_SEQ, P_CMD, P_LEN, P_ALO, P_AHI, P_DLO, P_DHI, P_SUM
    } pstate_t;
endpackage

// File: rtl/pkt_parser.sv
// Packet parser: walks the byte stream through the frame fields, keeps a
// running modulo-256 sum and emits a one-cycle write or read request when
// the closing checksum matches. Assumes rx_valid is a single-cycle strobe.
module pkt_parser
    import pktbr_pkg::*;
#(
    parameter logic [7:0] SYNC   = 8'hAA,
    parameter logic [7:0] CMD_WR = 8'h03,
    parameter logic [7:0] CMD_RD = 8'h04
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [7:0]        rx_byte,
    input  logic              rx_valid,
    output logic              req_wr,
    output logic              req_rd,
    output logic [ADDR_W-1:0] req_addr,
    output logic [DATA_W-1:0] req_wdata
);
    pstate_t    state;
    logic [7:0] sum;
    logic       is_wr;

    // Frame state machine, field capture and checksum accumulation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= P_HUNT;
            sum       <= '0;
            is_wr     <= 1'b0;
            req_addr  <= '0;
            req_wdata <= '0;
            req_wr    <= 1'b0;
            req_rd    <= 1'b0;
        end else begin
            req_wr <= 1'b0;
            req_rd <= 1'b0;
            if (rx_valid) begin
                sum <= sum + rx_byte;
                case (state)
                    P_HUNT: if (rx_byte == SYNC) begin
                        state <= P_SEQ;
                        sum   <= rx_byte;
                    end
                    P_SEQ: state <= P_CMD;
                    P_CMD: begin
                        if (rx_byte == CMD_WR) begin
                            is_wr <= 1'b1;
                            state <= P_LEN;
                        end else if (rx_byte == CMD_RD) begin
                            is_wr <= 1'b0;
                            state <= P_LEN;
                        end else begin
                            state <= P_HUNT;
                        end
                    end
                    P_LEN: state <= (rx_byte == 8'((is_wr ? WR_LEN : RD_LEN)))
                                    ? P_ALO : P_HUNT;
                    P_ALO: begin
                        req_addr[7:0] <= rx_byte;
                        state         <= P_AHI;
                    end
                    P_AHI: begin
                        req_addr[15:8] <= rx_byte;
                        state          <= is_wr ? P_DLO : P_SUM;
                    end
                    P_DLO: begin
                        req_wdata[7:0] <= rx_byte;
                        state          <= P_DHI;
                    end
                    P_DHI: begin
                        req_wdata[15:8] <= rx_byte;
                        state           <= P_SUM;
                    end
                    P_SUM: begin
                        state <= P_HUNT;
                        if (rx_byte == sum) begin
                            req_wr <= is_wr;
                            req_rd <= !is_wr;
                        end
                    end
                    default: state <= P_HUNT;
                endcase
            end
        end
    end

    // R9
    hunt_stays_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == P_HUNT && rx_valid && rx_byte != SYNC) |=> state == P_HUNT);

    // R8
    req_needs_sum_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_wr || req_rd) |-> $past(state == P_SUM && rx_valid));
endmodule

// File: rtl/bus_port.sv
// Bus port: turns parser requests into registered one-cycle bus strobes
// with stable address/data, and samples read data during the read strobe.
// Assumes the peripheral answers a read combinationally in the same cycle.
module bus_port
    import pktbr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_wr,
    input  logic              req_rd,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_wdata,
    output logic              bus_wr,
    output logic              bus_rd,
    input  logic [DATA_W-1:0] bus_rdata,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_data
);
    // Register strobes and their address/data; capture read response.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_addr  <= '0;
            bus_wdata <= '0;
            bus_wr    <= 1'b0;
            bus_rd    <= 1'b0;
            rsp_valid <= 1'b0;
            rsp_data  <= '0;
        end else begin
            bus_wr    <= req_wr;
            bus_rd    <= req_rd;
            rsp_valid <= bus_rd;
            if (req_wr || req_rd) begin
                bus_addr  <= req_addr;
                bus_wdata <= req_wdata;
            end
            if (bus_rd) rsp_data <= bus_rdata;
        end
    end

    // R5
    wr_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_wr |=> !bus_wr);

    // R6
    rd_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rd |=> !bus_rd);

    // R5
    wr_rd_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr && bus_rd));
endmodule

// File: rtl/reply_tx.sv
// Reply serializer: holds one read result and offers it byte by byte,
// low byte first, on a send/ready handshake. A new result replaces an
// unfinished one. Assumes tx_ready may stall for any number of cycles.
module reply_tx
    import pktbr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rsp_valid,
    input  logic [DATA_W-1:0] rsp_data,
    output logic [7:0]        tx_byte,
    output logic              tx_send,
    input  logic              tx_ready
);
    localparam int CNT_W = $clog2(DATA_BYTES + 1);

    logic [DATA_W-1:0] shreg;
    logic [CNT_W-1:0]  left;

    // Load a result, then shift one byte out per accepted handshake.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg <= '0;
            left  <= '0;
        end else if (rsp_valid) begin
            shreg <= rsp_data;
            left  <= CNT_W'(DATA_BYTES);
        end else if (tx_send && tx_ready) begin
            shreg <= shreg >> 8;
            left  <= left - 1'b1;
        end
    end

    assign tx_send = (left != '0);
    assign tx_byte = shreg[7:0];

    // R12
    tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_send && !tx_ready && !rsp_valid) |=> (tx_send && $stable(tx_byte)));
endmodule

// File: rtl/pkt_bridge.sv
// Top of the serial packet to register bus bridge: parser, bus port and
// reply serializer in a chain. Assumes one byte per rx_valid strobe.
module pkt_bridge #(
    parameter logic [7:0] SYNC   = 8'hAA,
    parameter logic [7:0] CMD_WR = 8'h03,
    parameter logic [7:0] CMD_RD = 8'h04
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [7:0]  rx_byte,
    input  logic        rx_valid,
    output logic [15:0] bus_addr,
    output logic [15:0] bus_wdata,
    output logic        bus_wr,
    output logic        bus_rd,
    input  logic [15:0] bus_rdata,
    output logic [7:0]  tx_byte,
    output logic        tx_send,
    input  logic        tx_ready
);
    import pktbr_pkg::*;

    logic              req_wr, req_rd, rsp_valid;
    logic [ADDR_W-1:0] req_addr;
    logic [DATA_W-1:0] req_wdata, rsp_data;

    pkt_parser #(.SYNC(SYNC), .CMD_WR(CMD_WR), .CMD_RD(CMD_RD)) u_parse (
        .clk(clk), .rst_n(rst_n), .rx_byte(rx_byte), .rx_valid(rx_valid),
        .req_wr(req_wr), .req_rd(req_rd), .req_addr(req_addr),
        .req_wdata(req_wdata)
    );

    bus_port u_bus (
        .clk(clk), .rst_n(rst_n), .req_wr(req_wr), .req_rd(req_rd),
        .req_addr(req_addr), .req_wdata(req_wdata), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_rdata(bus_rdata), .rsp_valid(rsp_valid), .rsp_data(rsp_data)
    );

    reply_tx u_reply (
        .clk(clk), .rst_n(rst_n), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
        .tx_byte(tx_byte), .tx_send(tx_send), .tx_ready(tx_ready)
    );

    // R7
    reply_after_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_send && !$past(tx_send)) |-> $past(bus_rd, 2));
endmodule

// File: tb/sim_pkt_bridge.sv
// Directed bench for pkt_bridge: one task per scenario, each checks itself.
module sim_pkt_bridge;
    localparam time CLK_PERIOD = 10ns;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  rx_byte = '0;
    logic        rx_valid = 1'b0;
    logic [15:0] bus_addr, bus_wdata, bus_rdata;
    logic        bus_wr, bus_rd, tx_send;
    logic [7:0]  tx_byte;
    logic        tx_ready = 1'b1;

    int checks = 0, errors = 0;
    int wr_cnt = 0, rd_cnt = 0, tx_cnt = 0;
    logic [15:0] wr_addr, wr_data, rd_addr;
    logic [7:0]  tx_seen [0:15];
    logic [7:0]  seq = 8'h1D;

    pkt_bridge u0 (
        .clk(clk), .rst_n(rst_n), .rx_byte(rx_byte), .rx_valid(rx_valid),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_rdata(bus_rdata), .tx_byte(tx_byte),
        .tx_send(tx_send), .tx_ready(tx_ready)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Peripheral model: read data derived from the address.
    assign bus_rdata = bus_addr ^ 16'h5A5A;

    // Monitor at the falling edge, away from the active edge.
    always @(negedge clk) begin
        if (rst_n && bus_wr) begin
            wr_cnt++; wr_addr = bus_addr; wr_data = bus_wdata;
        end
        if (rst_n && bus_rd) begin
            rd_cnt++; rd_addr = bus_addr;
        end
        if (rst_n && tx_send && tx_ready) begin
            if (tx_cnt < 16) tx_seen[tx_cnt] = tx_byte;
            tx_cnt++;
        end
    end

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic put(logic [7:0] b);
        @(negedge clk);
        rx_byte = b; rx_valid = 1'b1;
        @(negedge clk);
        rx_valid = 1'b0;
    endtask

    // Build and send a packet; bad_sum corrupts the checksum.
    task automatic send_pkt(logic [7:0] cmd, logic [7:0] len, logic [15:0] addr,
                            logic [15:0] data, bit with_data, bit bad_sum);
        logic [7:0] s;
        s = 8'hAA;            put(8'hAA);
        s += seq;             put(seq);
        seq++;
        s += cmd;             put(cmd);
        s += len;             put(len);
        s += addr[7:0];       put(addr[7:0]);
        s += addr[15:8];      put(addr[15:8]);
        if (with_data) begin
            s += data[7:0];   put(data[7:0]);
            s += data[15:8];  put(data[15:8]);
        end
        put(bad_sum ? s + 8'h01 : s);
        repeat (8) @(negedge clk);
    endtask

    task automatic t_reset();
        check("R5 reset bus_wr", 32'(bus_wr), 0);
        check("R6 reset bus_rd", 32'(bus_rd), 0);
        check("R7 reset tx_send", 32'(tx_send), 0);
    endtask

    task automatic t_write();
        int w0 = wr_cnt, r0 = rd_cnt;
        send_pkt(8'h03, 8'd4, 16'h0021, 16'hC000, 1, 0);
        check("R5 write count", wr_cnt - w0, 1);
        check("R5 no read on write", rd_cnt - r0, 0);
        check("R4 write address", 32'(wr_addr), 32'h0021);
        check("R4 write data", 32'(wr_data), 32'hC000);
    endtask

    task automatic t_read();
        int r0 = rd_cnt, t0 = tx_cnt;
        send_pkt(8'h04, 8'd2, 16'h1234, 16'h0, 0, 0);
        check("R6 read count", rd_cnt - r0, 1);
        check("R3 read address", 32'(rd_addr), 32'h1234);
        check("R7 reply byte count", tx_cnt - t0, 2);
        check("R7 reply low byte", 32'(tx_seen[t0]), 32'h6E);
        check("R7 reply high byte", 32'(tx_seen[t0+1]), 32'h48);
    endtask

    task automatic t_seq();
        int w0 = wr_cnt;
        for (int i = 0; i < 3; i++) send_pkt(8'h03, 8'd4, 16'h0030 + 16'(i), 16'h7000, 1, 0);
        check("R2 successive sequence values accepted", wr_cnt - w0, 3);
        check("R2 last write address", 32'(wr_addr), 32'h0032);
    endtask

    task automatic t_bad_sum();
        int w0 = wr_cnt, r0 = rd_cnt;
        send_pkt(8'h03, 8'd4, 16'h0040, 16'h1111, 1, 1);
        send_pkt(8'h04, 8'd2, 16'h0041, 16'h0, 0, 1);
        check("R8 bad checksum no write", wr_cnt - w0, 0);
        check("R8 bad checksum no read", rd_cnt - r0, 0);
    endtask

    task automatic t_noise();
        int w0 = wr_cnt, r0 = rd_cnt;
        put(8'h55); put(8'h03); put(8'h04); put(8'h00); put(8'hAB);
        repeat (6) @(negedge clk);
        check("R9 noise no write", wr_cnt - w0, 0);
        check("R9 noise no read", rd_cnt - r0, 0);
        send_pkt(8'h03, 8'd4, 16'h0050, 16'h9090, 1, 0);
        check("R1 sync after noise", wr_cnt - w0, 1);
        check("R1 address after noise", 32'(wr_addr), 32'h0050);
    endtask

    task automatic t_bad_cmd();
        int w0 = wr_cnt, r0 = rd_cnt;
        send_pkt(8'h05, 8'd4, 16'h0060, 16'h2222, 1, 0);
        check("R10 unknown command dropped", (wr_cnt - w0) + (rd_cnt - r0), 0);
        send_pkt(8'h03, 8'd4, 16'h0061, 16'h3333, 1, 0);
        check("R10 next packet accepted", wr_cnt - w0, 1);
        check("R3 write data after drop", 32'(wr_data), 32'h3333);
    endtask

    task automatic t_bad_len();
        int w0 = wr_cnt, r0 = rd_cnt;
        send_pkt(8'h03, 8'd2, 16'h0070, 16'h4444, 1, 0);
        send_pkt(8'h04, 8'd4, 16'h0071, 16'h0, 0, 0);
        check("R11 bad length no write", wr_cnt - w0, 0);
        check("R11 bad length no read", rd_cnt - r0, 0);
    endtask

    task automatic t_stall();
        int t0;
        logic [7:0] held;
        tx_ready = 1'b0;
        t0 = tx_cnt;
        send_pkt(8'h04, 8'd2, 16'hA5F0, 16'h0, 0, 0);
        check("R12 send raised while stalled", 32'(tx_send), 1);
        held = tx_byte;
        repeat (5) @(negedge clk);
        check("R12 send held", 32'(tx_send), 1);
        check("R12 byte held", 32'(tx_byte), 32'(held));
        check("R12 nothing taken while stalled", tx_cnt - t0, 0);
        tx_ready = 1'b1;
        repeat (4) @(negedge clk);
        check("R7 stalled reply low", 32'(tx_seen[t0]), 32'hAA);
        check("R7 stalled reply high", 32'(tx_seen[t0+1]), 32'hFF);
        check("R7 send drops after reply", 32'(tx_send), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_write();
        t_read();
        t_seq();
        t_bad_sum();
        t_noise();
        t_bad_cmd();
        t_bad_len();
        t_stall();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule